// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Address-Width Discovery

This block is a bit-level master for a three-wire serial EEPROM organised as 16-bit words, with a chip-select line, a serial clock, a data line into the memory and a data line out of it. After a start strobe it finds out how many address bits the attached part uses, then reads the whole part, word after word, and reports each word on a stream port together with its index. It finishes by posting the detected address width and whether the 16-bit wrapping sum of all words matches the expected image signature.

The width is not configured. The first access is a throw-away read of word zero during which the address is shifted out one bit at a time, assuming up to eight bits. The block watches the memory's output line after each address bit. The memory pulls that line low as soon as it has received its full address. The number of bits shifted up to that point is the width. The real reads then follow with that width. A programmable phase divider sets the serial clock rate so that slow parts can be met from a fast system clock.

The controller is one state machine with the states IDLE, SELECT, OPCODE, ADDRESS, DATA, DESELECT and FINISH. The three bit states step through three sub-phases each: SETUP, HIGH and LOW. The transitions are as follows:
- IDLE to SELECT on start.
- SELECT to OPCODE after one phase.
- OPCODE to ADDRESS after three bits.
- ADDRESS to DATA when the width is reached, or in the detection pass when the dummy zero appears.
- ADDRESS to DESELECT when no dummy zero appears within eight bits.
- DATA to DESELECT after sixteen bits.
- DESELECT to SELECT for the next read, or to FINISH after the last word or after an abort.
- FINISH to IDLE after one cycle.

Top module: `ee_auto_reader`

## Requirements
- R1: Out of reset, chip select, serial clock, data-to-memory, busy, done, word_vld, sum_ok and det_err are low, and addr_width is 0.
- R2: Every read raises chip select and then sends the three command bits 1, 1, 0 in that order. Each bit is placed on ee_di one phase before the clock rises and is held until the clock falls.
- R3: Each serial clock high phase lasts exactly phase_div+1 system clock cycles.
- R4: The first read after start shifts address zero MSB first and samples ee_do after each address bit. It stops at the first low sample, and addr_width then equals the number of address bits shifted (1 to 8).
- R5: After detection, words 0 to 2^addr_width-1 are read in increasing order. Each address is sent MSB first, and each word is reported with word_vld high for one cycle, word_idx equal to its address and word_dat equal to its content.
- R6: The sixteen data bits are sampled from ee_do while the serial clock is high, MSB first.
- R7: Chip select falls for at least one phase after every read, so a full run raises chip select 2^addr_width+1 times. The serial clock is only ever high while chip select is high.
- R8: sum_ok is high after a run only when the sum modulo 2^16 of all reported words equals 0xBABA.
- R9: If ee_do stays high through eight address bits, the block asserts det_err, reports no words, leaves addr_width at 0 and sum_ok low.
- R10: busy is high from the cycle after start until the one-cycle done pulse ends. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a detect-and-read run |
| phase_div | input | DIV_W | Serial clock phase length minus one, in system cycles |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when results are posted |
| word_vld | output | 1 | word_idx and word_dat carry a new word |
| word_idx | output | AW_MAX | Address of the reported word |
| word_dat | output | WORD_W | Content of the reported word |
| addr_width | output | AWC_W | Detected address width |
| sum_ok | output | 1 | Word sum matched the signature |
| det_err | output | 1 | No dummy zero seen during detection |

## Verification
A wrong state or sub-phase shows up at the pins within one serial phase. A misplaced clock pulse, a command bit out of order, or a data change while the clock is high appears on the very next clock edge of the memory, and the memory model then returns the wrong word. A bit counter that is off by one shows up as a wrong addr_width or a shifted word_dat on the first reported word. A wrong end-of-image compare shows up as a missing or extra word_vld and a wrong chip-select count by the done pulse. A corrupted sum register is only seen at sum_ok when the run finishes.

// File: rtl/ee_reader_pkg.sv
package ee_reader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_DESEL,
        ST_FIN
    } ee_state_t;

    typedef enum logic [1:0] {
        PH_SET,
        PH_HI,
        PH_LO
    } ee_phase_t;

    // start bit, then read opcode; bit 2 goes out first
    localparam logic [2:0] RD_CMD = 3'b110;

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ee_word_shifter.sv
module ee_word_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/ee_sum_check.sv
module ee_sum_check #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add,
    input  logic [W-1:0] val,
    output logic [W-1:0] sum
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + val;
        end
    end

    // R8: the running sum moves only on a clear or an added word
    a_r8_sum_moves_on_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(add) && !$past(clear)) |-> $stable(sum));

endmodule

// File: rtl/ee_auto_reader.sv
module ee_auto_reader
    import ee_reader_pkg::*;
#(
    parameter int          AW_MAX  = 8,
    parameter int          DIV_W   = 8,
    parameter int          WORD_W  = 16,
    parameter logic [15:0] SIG_VAL = 16'hBABA,
    localparam int         AWC_W   = $clog2(AW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  phase_div,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic              word_vld,
    output logic [AW_MAX-1:0] word_idx,
    output logic [WORD_W-1:0] word_dat,
    output logic [AWC_W-1:0]  addr_width,
    output logic              sum_ok,
    output logic              det_err
);

    localparam int              BC_MAX = (WORD_W > AW_MAX) ? WORD_W : AW_MAX;
    localparam int              BC_W   = $clog2(BC_MAX);
    localparam logic [AWC_W-1:0] AWM   = AWC_W'(AW_MAX);

    ee_state_t          st;
    ee_phase_t          ph;
    logic [BC_W-1:0]    bcnt;
    logic [AWC_W-1:0]   nsh;
    logic [AWC_W-1:0]   aw;
    logic [AW_MAX-1:0]  addr;
    logic               det_pass;
    logic               abort;

    logic               tick;
    logic               run;
    logic [AW_MAX-1:0]  adr_q;
    logic [WORD_W-1:0]  dat_q;
    logic [WORD_W-1:0]  sum;
    logic               accept;
    logic               in_bit;
    logic               adr_load;
    logic               adr_shift;
    logic               dat_shift;
    logic [AW_MAX-1:0]  adr_init;
    logic [AW_MAX-1:0]  last_addr;

    assign run       = (st != ST_IDLE) && (st != ST_FIN);
    assign accept    = (st == ST_IDLE) && start;
    assign in_bit    = (st == ST_OPC) || (st == ST_ADR) || (st == ST_DAT);
    assign adr_load  = tick && (st == ST_OPC) && (ph == PH_LO) && (bcnt == '0);
    assign adr_shift = tick && (st == ST_ADR) && (ph == PH_LO);
    assign dat_shift = tick && (st == ST_DAT) && (ph == PH_HI);
    assign adr_init  = det_pass ? '0 : (addr << (AWM - aw));
    assign last_addr = {AW_MAX{1'b1}} >> (AWM - aw);

    ee_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (phase_div),
        .tick (tick)
    );

    ee_word_shifter #(.W(AW_MAX)) u_adr_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (adr_load),
        .load_val(adr_init),
        .shift   (adr_shift),
        .sin     (1'b0),
        .q       (adr_q)
    );

    ee_word_shifter #(.W(WORD_W)) u_dat_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (1'b0),
        .load_val('0),
        .shift   (dat_shift),
        .sin     (ee_do),
        .q       (dat_q)
    );

    ee_sum_check #(.W(WORD_W)) u_sum (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(accept),
        .add  (word_vld),
        .val  (word_dat),
        .sum  (sum)
    );

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            ph         <= PH_SET;
            bcnt       <= '0;
            nsh        <= '0;
            aw         <= '0;
            addr       <= '0;
            det_pass   <= 1'b0;
            abort      <= 1'b0;
            word_vld   <= 1'b0;
            word_idx   <= '0;
            word_dat   <= '0;
            addr_width <= '0;
            sum_ok     <= 1'b0;
            det_err    <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st         <= ST_SEL;
                        ph         <= PH_SET;
                        det_pass   <= 1'b1;
                        abort      <= 1'b0;
                        addr       <= '0;
                        aw         <= '0;
                        addr_width <= '0;
                        sum_ok     <= 1'b0;
                        det_err    <= 1'b0;
                    end
                end
                ST_SEL: begin
                    if (tick) begin
                        st   <= ST_OPC;
                        ph   <= PH_SET;
                        bcnt <= BC_W'(2);
                    end
                end
                ST_OPC, ST_ADR, ST_DAT: begin
                    if (tick) begin
                        unique case (ph)
                            PH_SET: ph <= PH_HI;
                            PH_HI:  ph <= PH_LO;
                            PH_LO: begin
                                ph <= PH_SET;
                                if (st == ST_OPC) begin
                                    if (bcnt == '0) begin
                                        st   <= ST_ADR;
                                        nsh  <= '0;
                                        bcnt <= det_pass ? BC_W'(AW_MAX - 1)
                                                         : BC_W'(aw - 1'b1);
                                    end else begin
                                        bcnt <= bcnt - 1'b1;
                                    end
                                end else if (st == ST_ADR) begin
                                    if (det_pass && !ee_do) begin
                                        aw   <= nsh + 1'b1;
                                        st   <= ST_DAT;
                                        bcnt <= BC_W'(WORD_W - 1);
                                    end else if (bcnt == '0) begin
                                        if (det_pass) begin
                                            abort <= 1'b1;
                                            st    <= ST_DESEL;
                                        end else begin
                                            st   <= ST_DAT;
                                            bcnt <= BC_W'(WORD_W - 1);
                                        end
                                    end else begin
                                        bcnt <= bcnt - 1'b1;
                                        nsh  <= nsh + 1'b1;
                                    end
                                end else begin
                                    if (bcnt == '0) begin
                                        st <= ST_DESEL;
                                        if (!det_pass) begin
                                            word_vld <= 1'b1;
                                            word_idx <= addr;
                                            word_dat <= dat_q;
                                        end
                                    end else begin
                                        bcnt <= bcnt - 1'b1;
                                    end
                                end
                            end
                            default: ph <= PH_SET;
                        endcase
                    end
                end
                ST_DESEL: begin
                    if (tick) begin
                        ph <= PH_SET;
                        if (abort) begin
                            st <= ST_FIN;
                        end else if (det_pass) begin
                            det_pass <= 1'b0;
                            addr     <= '0;
                            st       <= ST_SEL;
                        end else if (addr == last_addr) begin
                            st <= ST_FIN;
                        end else begin
                            addr <= addr + 1'b1;
                            st   <= ST_SEL;
                        end
                    end
                end
                ST_FIN: begin
                    st         <= ST_IDLE;
                    det_err    <= abort;
                    sum_ok     <= !abort && (sum == SIG_VAL);
                    addr_width <= abort ? '0 : aw;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // pin and status outputs
    always_comb begin
        busy  = (st != ST_IDLE);
        done  = (st == ST_FIN);
        ee_cs = (st == ST_SEL) || in_bit;
        ee_sk = in_bit && (ph == PH_HI);
        ee_di = 1'b0;
        unique case (st)
            ST_OPC:  ee_di = RD_CMD[bcnt[1:0]];
            ST_ADR:  ee_di = adr_q[AW_MAX-1];
            default: ee_di = 1'b0;
        endcase
    end

    // R2: data toward the memory holds while the clock is high
    a_r2_di_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R7: the serial clock only pulses inside a selected read
    a_r7_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    // R10: busy only falls right after the done pulse
    a_r10_busy_drop_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R5: words are only reported during a run
    a_r5_word_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (busy && !ee_cs));

    // R9: a failed detection never reports a good image
    a_r9_err_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        det_err |-> !sum_ok);

endmodule

// File: tb/sim_ee_auto_reader.sv
module sim_ee_auto_reader;

    localparam int AW_MAX = 8;
    localparam int DIV_W  = 8;
    localparam int AWC_W  = $clog2(AW_MAX + 1);
    localparam int LIMIT  = 60000;

    localparam int NV = 5;
    localparam int V_AW   [NV] = '{6, 8, 1, 4, 7};
    localparam int V_DIV  [NV] = '{2, 0, 1, 3, 0};
    localparam int V_SEED [NV] = '{17, 3, 99, 41, 250};
    localparam int V_FIX  [NV] = '{1, 1, 1, 0, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIV_W-1:0]  phase_div = '0;
    logic              ee_cs, ee_sk, ee_di, ee_do;
    logic              busy, done, word_vld, sum_ok, det_err;
    logic [AW_MAX-1:0] word_idx;
    logic [15:0]       word_dat;
    logic [AWC_W-1:0]  addr_width;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ee_auto_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_div(phase_div),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .busy(busy), .done(done), .word_vld(word_vld), .word_idx(word_idx),
        .word_dat(word_dat), .addr_width(addr_width), .sum_ok(sum_ok),
        .det_err(det_err)
    );

    // serial memory model
    logic [15:0] mem [256];
    int          m_aw = 1;
    bit          m_present = 1'b1;
    int          m_st = 0;
    int          m_cnt = 0;
    int          m_addr = 0;
    logic [1:0]  m_op = '0;
    logic [15:0] m_word = '0;
    int          m_badop = 0;
    logic        m_do = 1'b1;

    assign ee_do = m_do;

    always @(posedge ee_cs) begin
        m_st = 0;
        m_do = 1'b1;
    end

    always @(negedge ee_cs) m_do = 1'b1;

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            case (m_st)
                0: begin
                    if (ee_di !== 1'b1) m_badop++;
                    m_st = 1; m_cnt = 0; m_op = '0;
                end
                1: begin
                    m_op = {m_op[0], ee_di};
                    m_cnt++;
                    if (m_cnt == 2) begin
                        if (m_op != 2'b10) m_badop++;
                        m_st = 2; m_cnt = 0; m_addr = 0;
                    end
                end
                2: begin
                    m_addr = (m_addr << 1) | int'(ee_di);
                    m_cnt++;
                    if (m_cnt == m_aw && m_present) begin
                        m_do = 1'b0;
                        m_word = mem[m_addr];
                        m_st = 3; m_cnt = 15;
                    end
                end
                3: begin
                    m_do = m_word[m_cnt];
                    if (m_cnt == 0) m_st = 4;
                    m_cnt--;
                end
                default: m_do = 1'b1;
            endcase
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(int aw, int seed, int fix);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(seed * 16'h0137 + i * 16'h2a51) ^ 16'(i << 5);
        end
        if (fix != 0) begin
            for (int i = 0; i < (1 << aw) - 1; i++) s = s + mem[i];
            mem[(1 << aw) - 1] = 16'hBABA - s;
        end
    endtask

    task automatic run_case(string nm, int aw, int dv, int seed, int fix,
                            bit present, bit poke);
        int          cyc, words, reads, hi_len, hi_bad, wbad, busy_low;
        logic        prev_cs;
        logic [15:0] exp_sum;
        int          exp_reads, exp_words;
        fill(aw, seed, fix);
        m_aw = aw;
        m_present = present;
        m_badop = 0;
        phase_div = DIV_W'(dv);
        exp_sum = '0;
        for (int i = 0; i < (1 << aw); i++) exp_sum = exp_sum + mem[i];
        exp_words = present ? (1 << aw) : 0;
        exp_reads = present ? (1 << aw) + 1 : 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0; words = 0; reads = 0; hi_len = 0; hi_bad = 0; wbad = 0;
        busy_low = 0; prev_cs = 1'b0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (poke) start = (cyc == 200);
            if (ee_cs && !prev_cs) reads++;
            prev_cs = ee_cs;
            if (ee_sk) hi_len++;
            else if (hi_len != 0) begin
                if (hi_len != dv + 1) hi_bad++;
                hi_len = 0;
            end
            if (word_vld) begin
                if (int'(word_idx) != words || word_dat != mem[words]) wbad++;
                words++;
            end
            if (!busy) busy_low++;
        end
        start = 1'b0;
        check({nm, " R10 run finished"}, int'(done), 1);
        check({nm, " R10 busy held"}, busy_low, 0);
        check({nm, " R2 command bits"}, m_badop, 0);
        check({nm, " R3 high phase length"}, hi_bad, 0);
        check({nm, " R7 select count"}, reads, exp_reads);
        check({nm, " R5 word count"}, words, exp_words);
        check({nm, " R6 word order/content"}, wbad, 0);
        @(negedge clk);
        check({nm, " R10 busy low after done"}, int'(busy), 0);
        if (present) begin
            check({nm, " R4 width"}, int'(addr_width), aw);
            check({nm, " R8 checksum flag"}, int'(sum_ok),
                  int'(exp_sum == 16'hBABA));
            check({nm, " R9 no error"}, int'(det_err), 0);
        end else begin
            check({nm, " R9 error flag"}, int'(det_err), 1);
            check({nm, " R9 width zero"}, int'(addr_width), 0);
            check({nm, " R9 sum not ok"}, int'(sum_ok), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs", int'(ee_cs), 0);
        check("R1 sk", int'(ee_sk), 0);
        check("R1 di", int'(ee_di), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 flags", int'({word_vld, sum_ok, det_err}), 0);
        check("R1 width", int'(addr_width), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'({busy, ee_cs}), 0);

        for (int v = 0; v < NV; v++) begin
            run_case($sformatf("vec%0d", v), V_AW[v], V_DIV[v], V_SEED[v],
                     V_FIX[v], 1'b1, 1'b0);
        end

        // R9 absent device, then R10 restart while busy
        run_case("absent", 3, 1, 7, 1, 1'b0, 1'b0);
        run_case("poke", 2, 0, 5, 1, 1'b1, 1'b1);
        // recovery after an error run
        run_case("absent2", 5, 0, 8, 1, 1'b0, 1'b0);
        run_case("after_err", 5, 0, 8, 1, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule